// File: doc/BRIEF.md
# Polynomial Segment Parameter Generator

This block produces one parameter of a waveform generator channel, such as an offset, an amplitude, a frequency or a phase, as a piecewise polynomial in time. Software or a sequencer writes a segment descriptor, called a knot, made of a start value and up to three difference terms. A separate update strobe, shared by every generator in the channel, moves the waiting knot into the working registers. From then on the block evaluates the polynomial by forward differencing and emits one new sample on every clock until the next knot is applied.

The polynomial order is fixed at build time. A cubic build carries the value and three difference terms. A linear build carries the value and one slope. A constant build holds the knot value unchanged. The difference terms carry extra fractional bits below the output LSB, so a slow ramp accumulates exactly and does not drift through truncation. All arithmetic wraps modulo the working width, which suits phase and frequency words. Every order has the same latency from the update strobe to the output, so several generators that share one strobe change value on the same clock.

Top module: `spline_interp`

## Requirements
- R1: While reset is held, and on the first sample after it, `param_out` is 0 and no knot is waiting.
- R2: A knot written with `knot_valid` is only held in staging. `param_out` keeps evolving from the previous working state until an update applies the knot.
- R3: If `update` is high on a rising edge while a knot is waiting, the knot's value appears on `param_out` one rising edge later. The latency is the same for every ORDER, so generators that share `update` switch on the same sample.
- R4: Cubic build (ORDER=3): on each clock without a load, the working registers step as v += d1, d1 += d2, d2 += d3, all three from the previous values, and d3 is held. After n steps the accumulator therefore equals (value << FRAC_W) + n*d1 + n(n-1)/2*d2 + n(n-1)(n-2)/6*d3.
- R5: Linear build (ORDER=1): the accumulator gains d1 on each clock, giving (value << FRAC_W) + n*d1. `knot_d2` and `knot_d3` have no effect.
- R6: Constant build (ORDER=0): `param_out` holds the knot value. `knot_d1`, `knot_d2` and `knot_d3` have no effect.
- R7: An `update` pulse with no knot waiting changes nothing, and integration of the current segment continues without a break.
- R8: If `knot_valid` and `update` are high on the same edge, the update applies whichever knot was already waiting, and the newly written knot waits for the next update. If no knot was waiting, no load takes place on that edge.
- R9: The accumulator is OUT_W+FRAC_W bits wide and wraps modulo 2^(OUT_W+FRAC_W). `param_out` is always the top OUT_W bits of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| knot_valid | input | 1 | Writes the knot fields into staging |
| knot_value | input | OUT_W | Segment start value, integer part |
| knot_d1 | input | OUT_W+FRAC_W | First difference term, with FRAC_W fractional bits |
| knot_d2 | input | OUT_W+FRAC_W | Second difference term |
| knot_d3 | input | OUT_W+FRAC_W | Third difference term |
| update | input | 1 | Shared strobe that applies a waiting knot |
| param_out | output | OUT_W | Parameter sample, new every clock |

## Verification
Several properties are checked on every cycle by the assertions: a load copies the staged value into the accumulator, the output follows a load with a fixed delay, a constant build stays still between loads, a linear build has a constant step, a cubic build holds its third difference, and an update with no new knot clears the waiting flag. The bench alone can show that the integrated values match the closed-form polynomials sample by sample over long segments, including across wraparound. It also checks that three builds of different order fed by one strobe change on the same sample, and it covers the ordering cases in which a knot write and an update fall on the same edge.

// File: rtl/spline_pkg.sv
// Package spline_pkg
// Shared constants for the polynomial segment generator. It holds the legal
// build orders and the helper that gives the working accumulator width.
package spline_pkg;
    localparam int ORD_CONST  = 0;
    localparam int ORD_LINEAR = 1;
    localparam int ORD_CUBIC  = 3;

    // Working width: output integer bits plus fractional guard bits.
    function automatic int acc_width(input int out_w, input int frac_w);
        return out_w + frac_w;
    endfunction
endpackage

// File: rtl/spline_knot_stage.sv
// Module spline_knot_stage
// Holds one written knot until the shared update strobe applies it. It
// raises load only when update meets a waiting knot. A knot written on the
// same edge as an update stays waiting for the next one.
// Assumes: synchronous active-low reset. Fields are captured whole.
module spline_knot_stage #(
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 16,
    localparam int ACC_W = OUT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             knot_valid,
    input  logic [OUT_W-1:0] knot_value,
    input  logic [ACC_W-1:0] knot_d1,
    input  logic [ACC_W-1:0] knot_d2,
    input  logic [ACC_W-1:0] knot_d3,
    input  logic             update,
    output logic [OUT_W-1:0] st_value,
    output logic [ACC_W-1:0] st_d1,
    output logic [ACC_W-1:0] st_d2,
    output logic [ACC_W-1:0] st_d3,
    output logic             pending,
    output logic             load
);
    // Capture the knot fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_value <= '0;
            st_d1    <= '0;
            st_d2    <= '0;
            st_d3    <= '0;
        end else if (knot_valid) begin
            st_value <= knot_value;
            st_d1    <= knot_d1;
            st_d2    <= knot_d2;
            st_d3    <= knot_d3;
        end
    end

    // Track whether a knot is waiting. A new write wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          pending <= 1'b0;
        else if (knot_valid) pending <= 1'b1;
        else if (update)     pending <= 1'b0;
    end

    // Apply the waiting knot when the shared strobe arrives.
    assign load = update & pending;

    assert_pending_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !knot_valid) |=> !pending);

    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !knot_valid |=> ($stable(st_value) && $stable(st_d1) && $stable(st_d2) && $stable(st_d3)));
endmodule

// File: rtl/spline_fd_engine.sv
// Module spline_fd_engine
// Forward-difference integrator whose order is chosen at build time. On
// load it takes the staged value, placed above FRAC_W zero bits, and the
// difference terms. Otherwise it steps once per clock. Sums wrap modulo
// 2^ACC_W.
// Assumes: ORDER is 0, 1 or 3. Terms a build does not need are not stored.
module spline_fd_engine #(
    parameter int ORDER  = 3,
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 16,
    localparam int ACC_W = OUT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OUT_W-1:0] st_value,
    input  logic [ACC_W-1:0] st_d1,
    input  logic [ACC_W-1:0] st_d2,
    input  logic [ACC_W-1:0] st_d3,
    output logic [ACC_W-1:0] acc
);
    import spline_pkg::*;

    logic [ACC_W-1:0] load_word;
    logic [1:0]       age;

    // Place the integer value above the fractional guard bits.
    assign load_word = {st_value, {FRAC_W{1'b0}}};

    // Count cycles since reset, saturating, so the checks never look past reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    generate
        if (ORDER == ORD_CONST) begin : g_const
            // Hold the knot value between loads.
            always_ff @(posedge clk) begin
                if (!rst_n)    acc <= '0;
                else if (load) acc <= load_word;
            end

            assert_const_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !load |=> $stable(acc));

            // The difference inputs are not used by this build.
            logic unused_terms;
            assign unused_terms = ^{st_d1, st_d2, st_d3};
        end else if (ORDER == ORD_LINEAR) begin : g_linear
            logic [ACC_W-1:0] d1_q;

            // Add the slope every clock. Load the new value and slope on a knot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc  <= '0;
                    d1_q <= '0;
                end else if (load) begin
                    acc  <= load_word;
                    d1_q <= st_d1;
                end else begin
                    acc  <= acc + d1_q;
                end
            end

            assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (age == 2'd3 && !$past(load) && !$past(load, 2)) |->
                ((acc - $past(acc)) == ($past(acc) - $past(acc, 2))));

            logic unused_terms;
            assign unused_terms = ^{st_d2, st_d3};
        end else if (ORDER == ORD_CUBIC) begin : g_cubic
            logic [ACC_W-1:0] d1_q, d2_q, d3_q;

            // Step value and differences together, each from last cycle's values.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc  <= '0;
                    d1_q <= '0;
                    d2_q <= '0;
                    d3_q <= '0;
                end else if (load) begin
                    acc  <= load_word;
                    d1_q <= st_d1;
                    d2_q <= st_d2;
                    d3_q <= st_d3;
                end else begin
                    acc  <= acc + d1_q;
                    d1_q <= d1_q + d2_q;
                    d2_q <= d2_q + d3_q;
                end
            end

            assert_cubic_d3_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !load |=> $stable(d3_q));
        end else begin : g_bad_order
            $error("spline_fd_engine: ORDER must be 0, 1 or 3");
        end
    endgenerate

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc == {$past(st_value), {FRAC_W{1'b0}}}));
endmodule

// File: rtl/spline_out_reg.sv
// Module spline_out_reg
// Registers the integer part of the accumulator as the parameter sample.
// The stage is the same for every order, so latency is the same in all
// builds.
// Assumes: FRAC_W >= 1. The guard bits are dropped here.
module spline_out_reg #(
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 16,
    localparam int ACC_W = OUT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc,
    output logic [OUT_W-1:0] param_out
);
    logic unused_frac;
    assign unused_frac = ^acc[FRAC_W-1:0];

    // Take the top OUT_W accumulator bits once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) param_out <= '0;
        else        param_out <= acc[ACC_W-1:FRAC_W];
    end
endmodule

// File: rtl/spline_interp.sv
// Module spline_interp
// Top of the polynomial segment parameter generator. It chains knot
// staging, the forward-difference engine and the output register. A knot
// applied on update appears on param_out one edge after the load edge.
// Assumes: update is shared by every generator that must switch together.
module spline_interp #(
    parameter int ORDER  = 3,
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    knot_valid,
    input  logic [OUT_W-1:0]        knot_value,
    input  logic [OUT_W+FRAC_W-1:0] knot_d1,
    input  logic [OUT_W+FRAC_W-1:0] knot_d2,
    input  logic [OUT_W+FRAC_W-1:0] knot_d3,
    input  logic                    update,
    output logic [OUT_W-1:0]        param_out
);
    localparam int ACC_W = spline_pkg::acc_width(OUT_W, FRAC_W);

    logic [OUT_W-1:0] st_value;
    logic [ACC_W-1:0] st_d1, st_d2, st_d3;
    logic             pending, load;
    logic [ACC_W-1:0] acc;

    spline_knot_stage #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .knot_valid(knot_valid),
        .knot_value(knot_value), .knot_d1(knot_d1), .knot_d2(knot_d2),
        .knot_d3(knot_d3), .update(update),
        .st_value(st_value), .st_d1(st_d1), .st_d2(st_d2), .st_d3(st_d3),
        .pending(pending), .load(load)
    );

    spline_fd_engine #(.ORDER(ORDER), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .load(load), .st_value(st_value),
        .st_d1(st_d1), .st_d2(st_d2), .st_d3(st_d3), .acc(acc)
    );

    spline_out_reg #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_out (
        .clk(clk), .rst_n(rst_n), .acc(acc), .param_out(param_out)
    );

    assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ##1 (param_out == $past(st_value, 2)));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (param_out == '0 && !pending));
endmodule

// File: tb/sim_spline_interp.sv
module sim_spline_interp;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [2:0] kv = '0;
    logic upd = 1'b0;

    logic [15:0] c_val = '0; logic [31:0] c_d1 = '0, c_d2 = '0, c_d3 = '0;
    logic [47:0] l_val = '0; logic [63:0] l_d1 = '0, l_d2 = '0, l_d3 = '0;
    logic [15:0] k_val = '0; logic [23:0] k_d1 = '0, k_d2 = '0, k_d3 = '0;
    logic [15:0] p0, p2;
    logic [47:0] p1;

    spline_interp #(.ORDER(3), .OUT_W(16), .FRAC_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .knot_valid(kv[0]), .knot_value(c_val),
        .knot_d1(c_d1), .knot_d2(c_d2), .knot_d3(c_d3), .update(upd), .param_out(p0));
    spline_interp #(.ORDER(1), .OUT_W(48), .FRAC_W(16)) u1 (
        .clk(clk), .rst_n(rst_n), .knot_valid(kv[1]), .knot_value(l_val),
        .knot_d1(l_d1), .knot_d2(l_d2), .knot_d3(l_d3), .update(upd), .param_out(p1));
    spline_interp #(.ORDER(0), .OUT_W(16), .FRAC_W(8)) u2 (
        .clk(clk), .rst_n(rst_n), .knot_valid(kv[2]), .knot_value(k_val),
        .knot_d1(k_d1), .knot_d2(k_d2), .knot_d3(k_d3), .update(upd), .param_out(p2));

    int checks = 0;
    int errors = 0;
    string cur_tag = "";
    int ORD[3] = '{3, 1, 0};
    int OW[3]  = '{16, 48, 16};
    int FW[3]  = '{16, 16, 8};
    string RQ[3] = '{"R4", "R5", "R6"};

    // Bench model: written, staged, working and output-visible knots.
    logic [63:0] nk_v[3], nk_1[3], nk_2[3], nk_3[3];
    logic [63:0] st_v[3], st_1[3], st_2[3], st_3[3];
    logic        st_p[3];
    logic [63:0] a_v[3], a_1[3], a_2[3], a_3[3];
    logic [63:0] o_v[3], o_1[3], o_2[3], o_3[3];
    int          a_n[3], o_n[3];

    function automatic logic [63:0] msk(input logic [63:0] x, input int w);
        if (w >= 64) return x;
        return x & ((64'd1 << w) - 64'd1);
    endfunction

    // Closed-form value per R4, R5, R6 with R9 wraparound.
    function automatic logic [63:0] poly(input int ord, input int ow, input int fw,
        input logic [63:0] v, input logic [63:0] d1, input logic [63:0] d2,
        input logic [63:0] d3, input int n);
        logic [127:0] acc, nn, am;
        nn  = 128'(n);
        acc = {64'd0, v} << fw;
        if (ord >= 1) acc = acc + nn * {64'd0, d1};
        if (ord == 3) acc = acc + ((nn * (nn - 1)) / 2) * {64'd0, d2}
                                + ((nn * (nn - 1) * (nn - 2)) / 6) * {64'd0, d3};
        am  = (128'd1 << (ow + fw)) - 128'd1;
        acc = acc & am;
        return msk(64'(acc >> fw), ow);
    endfunction

    task automatic set_knot(input int i, input logic [63:0] v, input logic [63:0] d1,
                            input logic [63:0] d2, input logic [63:0] d3);
        nk_v[i] = msk(v, OW[i]);
        nk_1[i] = msk(d1, OW[i] + FW[i]);
        nk_2[i] = msk(d2, OW[i] + FW[i]);
        nk_3[i] = msk(d3, OW[i] + FW[i]);
        kv[i] = 1'b1;
        case (i)
            0: begin c_val = nk_v[0][15:0]; c_d1 = nk_1[0][31:0]; c_d2 = nk_2[0][31:0]; c_d3 = nk_3[0][31:0]; end
            1: begin l_val = nk_v[1][47:0]; l_d1 = nk_1[1]; l_d2 = nk_2[1]; l_d3 = nk_3[1]; end
            default: begin k_val = nk_v[2][15:0]; k_d1 = nk_1[2][23:0]; k_d2 = nk_2[2][23:0]; k_d3 = nk_3[2][23:0]; end
        endcase
    endtask

    task automatic check_all();
        for (int i = 0; i < 3; i++) begin
            logic [63:0] act, exp_v;
            act = (i == 0) ? {48'd0, p0} : (i == 1) ? {16'd0, p1} : {48'd0, p2};
            exp_v = poly(ORD[i], OW[i], FW[i], o_v[i], o_1[i], o_2[i], o_3[i], o_n[i]);
            checks++;
            if (act !== exp_v) begin
                errors++;
                $display("FAIL %s u%0d sample %0d actual %h expected %h",
                         (cur_tag == "") ? RQ[i] : cur_tag, i, o_n[i], act, exp_v);
            end
        end
    endtask

    // One clock: advance the model at the edge, then sample at the falling edge.
    task automatic step();
        @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            o_v[i] = a_v[i]; o_1[i] = a_1[i]; o_2[i] = a_2[i]; o_3[i] = a_3[i]; o_n[i] = a_n[i];
            if (upd && st_p[i]) begin
                a_v[i] = st_v[i]; a_1[i] = st_1[i]; a_2[i] = st_2[i]; a_3[i] = st_3[i]; a_n[i] = 0;
            end else begin
                a_n[i] = a_n[i] + 1;
            end
            if (kv[i]) begin
                st_v[i] = nk_v[i]; st_1[i] = nk_1[i]; st_2[i] = nk_2[i]; st_3[i] = nk_3[i]; st_p[i] = 1'b1;
            end else if (upd) begin
                st_p[i] = 1'b0;
            end
        end
        @(negedge clk);
        kv = '0;
        upd = 1'b0;
        check_all();
    endtask

    task automatic steps(input int n);
        for (int s = 0; s < n; s++) step();
    endtask

    task automatic knot_set(input int k);
        set_knot(0, 64'(16'h0fa0 * k + 16'h0123), 64'(-200000 + k * 70001),
                 64'(50 - k * 37), 64'(k * 3 - 5));
        set_knot(1, 64'(48'h0000_1234_5600 * k), 64'(64'h0000_0100_0000_0000) - 64'(k * 64'h0000_0080_0000_1111),
                 64'(k + 1), 64'(k * 7 + 2));
        set_knot(2, 64'(16'h1111 * k + 16'h00ab), 64'(k * 99 + 1), 64'(k + 5), 64'(3));
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            nk_v[i] = '0; nk_1[i] = '0; nk_2[i] = '0; nk_3[i] = '0;
            st_v[i] = '0; st_1[i] = '0; st_2[i] = '0; st_3[i] = '0; st_p[i] = 1'b0;
            a_v[i] = '0; a_1[i] = '0; a_2[i] = '0; a_3[i] = '0; a_n[i] = 0;
            o_v[i] = '0; o_1[i] = '0; o_2[i] = '0; o_3[i] = '0; o_n[i] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs are zero after reset.
        cur_tag = "R1";
        checks++;
        if (p0 !== 16'd0 || p1 !== 48'd0 || p2 !== 16'd0) begin
            errors++;
            $display("FAIL R1 in reset actual %h %h %h expected 0", p0, p1, p2);
        end
        rst_n = 1'b1;
        steps(2);

        // R2: staged knot leaves the outputs untouched until update.
        cur_tag = "R2";
        for (int i = 0; i < 3; i++) set_knot(i, 64'h7777, 64'h0003_0000, 64'h10, 64'h1);
        steps(4);

        // R3: update applies it, and all three switch on the same sample.
        cur_tag = "R3";
        upd = 1'b1;
        steps(2);
        cur_tag = "";
        steps(30);

        // R4, R5, R6: sweep of segments checked against closed forms.
        for (int k = 0; k < 5; k++) begin
            knot_set(k);
            step();
            upd = 1'b1;
            steps(150);
        end

        // R7: update with nothing waiting keeps the segment running.
        cur_tag = "R7";
        upd = 1'b1;
        steps(25);

        // R8: write and update together with nothing waiting: no load yet.
        cur_tag = "R8";
        knot_set(6);
        upd = 1'b1;
        steps(10);
        upd = 1'b1;
        steps(20);
        // R8: write and update together with a knot waiting: old one applies.
        knot_set(7);
        step();
        knot_set(8);
        upd = 1'b1;
        steps(12);
        upd = 1'b1;
        steps(12);

        // R9: accumulator wraps modulo its width.
        cur_tag = "R9";
        set_knot(0, 64'hfff0, 64'h0008_0000, 64'h0000_4000, 64'h0);
        set_knot(1, 64'hffff_ffff_fff0, 64'h0000_0000_0004_0000, 64'h0, 64'h0);
        set_knot(2, 64'hffff, 64'h0, 64'h0, 64'h0);
        step();
        upd = 1'b1;
        steps(40);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule